// File: doc/BRIEF.md
# Format-Adaptive Sync Deglitch Filter

This block cleans up digitized video sync lines before they reach polarity detection. It runs on a free-running crystal-domain clock. Each lane (horizontal, vertical or composite sync) is first brought into that clock domain through two flops. A width counter then removes any excursion, high or low, that is shorter than a minimum width. The output moves to a new level only after the synchronized input has held that level for the full minimum width. Any shorter excursion leaves the output where it was.

The minimum width is not a fixed constant. In automatic mode a format-class input chooses it: standard and interlaced component video up to 1080i gets a long window, while progressive 1080p component and graphics formats get a short one. In manual mode a register-supplied width is used instead. Setting a non-zero fixed-width parameter gives a second variant of the same logic. That variant ignores all configuration and always rejects pulses shorter than the fixed width, as a non-configurable pixel-clock-side filter needs.

Top module: `sdg_deglitch_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every lane output is 1, the inactive level of a negative-going sync.
- R2: With manual_en = 0 and fmt_class = 0 (component up to 1080i), an excursion held for fewer than 5 clocks never reaches the output, and one held for 5 or more clocks does.
- R3: With manual_en = 0 and fmt_class = 1 (1080p component), 2 (graphics) or 3 (reserved, treated as short), a 1-clock excursion is suppressed and a 2-clock excursion passes.
- R4: With manual_en = 1, the minimum width is manual_width and fmt_class has no effect. A manual_width of 0 acts as 1, so every excursion passes.
- R5: The filter is symmetric. A short high excursion on a lane that rests low is suppressed by the same rule as a short low excursion on a lane that rests high.
- R6: When a lane's input changes and then holds for the minimum width N, the output takes the new level on the (N+2)-th rising edge after the change. An output change is always preceded by the input holding the new level.
- R7: A configuration change made while a lane is stable does not change that lane's output. The new width is registered and governs the next input transition.
- R8: Lanes are independent. A pulse on one lane never changes another lane's output.
- R9: With FIXED_WIDTH > 0, the minimum width is FIXED_WIDTH whatever manual_en, manual_width and fmt_class are.
- R10: Under any mix of input toggles and configuration changes, every output matches a cycle-accurate reference of rules R1 to R9 on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_raw | input | LANES | Raw sync inputs, asynchronous to clk |
| fmt_class | input | 2 | Video format class: 0 component up to 1080i, 1 component 1080p, 2 graphics, 3 reserved |
| manual_en | input | 1 | 0 selects the format-driven width, 1 selects manual_width |
| manual_width | input | CNT_W | Manual minimum pulse width in clocks (0 acts as 1) |
| sync_clean | output | LANES | Filtered sync outputs |

## Verification
For a minimum width N, a change on a raw input is due at the output on the (N+2)-th rising edge after the change. Two of those edges are the synchronizer and N are the width count. A configuration change counts from the edge after it is applied, because the selected width is registered. The bench drives inputs on falling edges and samples outputs on falling edges. Its reference keeps a two-deep queue of raw samples and a per-lane streak count, so it predicts the exact edge of every change. The directed latency checks sample the output once one edge before the predicted change and once just after it, to pin down the edge exactly.

// File: rtl/sdg_pkg.sv
package sdg_pkg;

    // Format class encoding seen on the fmt_class port.
    typedef enum logic [1:0] {
        FMT_COMP_SD    = 2'd0,
        FMT_COMP_PROG  = 2'd1,
        FMT_GRAPHICS   = 2'd2,
        FMT_RESERVED   = 2'd3
    } fmt_class_e;

    // Configuration captured every cycle by the width selector.
    typedef struct packed {
        logic       manual;
        fmt_class_e fmt;
    } width_cfg_t;

    // Sync lines rest high (negative-going pulses).
    localparam logic SYNC_IDLE = 1'b1;

    // Pick the minimum pulse width for a configuration.
    function automatic int pick_width(
        input width_cfg_t cfg,
        input int         manual_w,
        input int         long_w,
        input int         short_w
    );
        int w;
        if (cfg.manual) begin
            w = (manual_w == 0) ? 1 : manual_w;
        end else if (cfg.fmt == FMT_COMP_SD) begin
            w = long_w;
        end else begin
            w = short_w;
        end
        return w;
    endfunction

endpackage

// File: rtl/sdg_sync2.sv
module sdg_sync2 #(
    parameter int   W       = 3,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= {W{RST_VAL}};
            stab_q <= {W{RST_VAL}};
        end else begin
            meta_q <= d_async;
            stab_q <= meta_q;
        end
    end

    assign q_sync = stab_q;

endmodule

// File: rtl/sdg_width_sel.sv
module sdg_width_sel
    import sdg_pkg::*;
#(
    parameter int CNT_W       = 4,
    parameter int LONG_WIDTH  = 5,
    parameter int SHORT_WIDTH = 2,
    parameter int FIXED_WIDTH = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  width_cfg_t       cfg,
    input  logic [CNT_W-1:0] manual_width,
    output logic [CNT_W-1:0] thr_q
);

    localparam int          RESET_W  = (FIXED_WIDTH > 0) ? FIXED_WIDTH : LONG_WIDTH;
    localparam logic [CNT_W-1:0] RESET_THR = CNT_W'(RESET_W);

    generate
        if (FIXED_WIDTH > 0) begin : g_fixed
            // Configuration is deliberately not observed in this variant.
            logic unused_cfg;
            assign unused_cfg = ^{cfg, manual_width};

            always_ff @(posedge clk) begin
                if (rst) begin
                    thr_q <= RESET_THR;
                end else begin
                    thr_q <= RESET_THR;
                end
            end
        end else begin : g_adaptive
            logic [CNT_W-1:0] thr_d;

            always_comb begin
                thr_d = CNT_W'(pick_width(cfg, int'(manual_width),
                                          LONG_WIDTH, SHORT_WIDTH));
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    thr_q <= RESET_THR;
                end else begin
                    thr_q <= thr_d;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/sdg_lane_filter.sv
module sdg_lane_filter
    import sdg_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             s_in,
    input  logic [CNT_W-1:0] thr,
    output logic             level_q
);

    localparam int ACC_W = CNT_W + 1;

    logic [CNT_W-1:0] run_q;
    logic [ACC_W-1:0] run_inc;
    logic             differs;
    logic             reached;

    always_comb begin
        differs = s_in ^ level_q;
        run_inc = {1'b0, run_q} + ACC_W'(1);
        reached = (run_inc >= {1'b0, thr});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= SYNC_IDLE;
            run_q   <= '0;
        end else if (!differs) begin
            run_q   <= '0;
        end else if (reached) begin
            level_q <= s_in;
            run_q   <= '0;
        end else begin
            run_q   <= run_inc[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/sdg_deglitch_top.sv
module sdg_deglitch_top
    import sdg_pkg::*;
#(
    parameter int LANES       = 3,
    parameter int CNT_W       = 4,
    parameter int LONG_WIDTH  = 5,
    parameter int SHORT_WIDTH = 2,
    parameter int FIXED_WIDTH = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] sync_raw,
    input  logic [1:0]       fmt_class,
    input  logic             manual_en,
    input  logic [CNT_W-1:0] manual_width,
    output logic [LANES-1:0] sync_clean
);

    logic [LANES-1:0] sync_s;
    logic [CNT_W-1:0] thr_q;
    width_cfg_t       cfg;

    always_comb begin
        cfg.manual = manual_en;
        cfg.fmt    = fmt_class_e'(fmt_class);
    end

    sdg_sync2 #(
        .W       (LANES),
        .RST_VAL (SYNC_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (sync_raw),
        .q_sync  (sync_s)
    );

    sdg_width_sel #(
        .CNT_W       (CNT_W),
        .LONG_WIDTH  (LONG_WIDTH),
        .SHORT_WIDTH (SHORT_WIDTH),
        .FIXED_WIDTH (FIXED_WIDTH)
    ) u_width (
        .clk          (clk),
        .rst          (rst),
        .cfg          (cfg),
        .manual_width (manual_width),
        .thr_q        (thr_q)
    );

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            sdg_lane_filter #(
                .CNT_W (CNT_W)
            ) u_filt (
                .clk     (clk),
                .rst     (rst),
                .s_in    (sync_s[i]),
                .thr     (thr_q),
                .level_q (sync_clean[i])
            );
        end
    endgenerate

endmodule

// File: rtl/sdg_deglitch_checker.sv
module sdg_deglitch_checker #(
    parameter int LANES = 3,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [LANES-1:0] sync_raw,
    input logic [LANES-1:0] sync_s,
    input logic [LANES-1:0] sync_clean,
    input logic [CNT_W-1:0] thr_q
);

    // R1: outputs idle high right after a reset cycle
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (sync_clean == {LANES{1'b1}}));

    // R4: the selected width is never zero
    p_width_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
        thr_q != '0);

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_chk
            // R6: a change is preceded by the raw input holding the new level
            p_flip_follows_raw_r6: assert property (@(posedge clk) disable iff (rst)
                (sync_clean[i] != $past(sync_clean[i]))
                |-> ($past(sync_raw[i], 3) == sync_clean[i]));

            // R3: with a width of two or more, one synchronized sample cannot flip
            p_two_sample_min_r3: assert property (@(posedge clk) disable iff (rst)
                ((sync_clean[i] != $past(sync_clean[i])) && ($past(thr_q) >= 2))
                |-> ($past(sync_s[i], 2) == sync_clean[i]));

            // R7: matching input keeps the output where it is
            p_hold_on_match_r7: assert property (@(posedge clk) disable iff (rst)
                ($past(sync_s[i]) == $past(sync_clean[i]))
                |-> (sync_clean[i] == $past(sync_clean[i])));
        end
    endgenerate

endmodule

bind sdg_deglitch_top sdg_deglitch_checker #(
    .LANES (LANES),
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sync_raw   (sync_raw),
    .sync_s     (sync_s),
    .sync_clean (sync_clean),
    .thr_q      (thr_q)
);

// File: tb/sdg_deglitch_top_bench.sv
module sdg_deglitch_top_bench;

    localparam int LANES = 3;
    localparam int CNT_W = 4;
    localparam int FIXW  = 7;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [LANES-1:0] sync_raw = '1;
    logic [1:0]       fmt_class = 2'd0;
    logic             manual_en = 1'b0;
    logic [CNT_W-1:0] manual_width = '0;
    logic [LANES-1:0] sync_clean;
    logic [LANES-1:0] fix_clean;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";
    bit    done     = 1'b0;

    always #10 clk = ~clk;

    sdg_deglitch_top #(.LANES(LANES), .CNT_W(CNT_W)) u_sdg_deglitch_top (
        .clk(clk), .rst(rst), .sync_raw(sync_raw), .fmt_class(fmt_class),
        .manual_en(manual_en), .manual_width(manual_width), .sync_clean(sync_clean));

    sdg_deglitch_top #(.LANES(LANES), .CNT_W(CNT_W), .FIXED_WIDTH(FIXW)) u_fixed (
        .clk(clk), .rst(rst), .sync_raw(sync_raw), .fmt_class(fmt_class),
        .manual_en(manual_en), .manual_width(manual_width), .sync_clean(fix_clean));

    // Reference: two-deep raw queue, then a streak count per lane.
    bit m_pipe  [LANES][$];
    bit m_clean [2][LANES];
    bit m_last  [2][LANES];
    int m_streak[2][LANES];
    int m_thr;

    function automatic int ref_width(logic men, logic [CNT_W-1:0] mw, logic [1:0] fc);
        if (men) return (mw == 0) ? 1 : int'(mw);
        return (fc == 2'd0) ? 5 : 2;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int l = 0; l < LANES; l++) begin
                m_pipe[l] = {1'b1, 1'b1};
                for (int k = 0; k < 2; k++) begin
                    m_clean[k][l] = 1'b1; m_last[k][l] = 1'b1; m_streak[k][l] = 0;
                end
            end
            m_thr = 5;
        end else begin
            for (int l = 0; l < LANES; l++) begin
                bit s;
                s = m_pipe[l][0];
                for (int k = 0; k < 2; k++) begin
                    int w;
                    w = (k == 1) ? FIXW : m_thr;
                    if (s == m_last[k][l]) m_streak[k][l]++;
                    else begin m_streak[k][l] = 1; m_last[k][l] = s; end
                    if (s != m_clean[k][l] && m_streak[k][l] >= w) m_clean[k][l] = s;
                end
                void'(m_pipe[l].pop_front());
                m_pipe[l].push_back(sync_raw[l]);
            end
            m_thr = ref_width(manual_en, manual_width, fmt_class);
        end
    end

    task automatic check_bit(string tag, logic got, logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference (both variants).
    always @(negedge clk) begin
        if (!rst && !done) begin
            for (int l = 0; l < LANES; l++) begin
                check_bit({cur_req, " ref main"}, sync_clean[l], m_clean[0][l]);
                check_bit({"R9 ref fixed"}, fix_clean[l], m_clean[1][l]);
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse(int lane, logic lvl, int len);
        sync_raw[lane] = lvl;
        repeat (len) @(negedge clk);
        sync_raw[lane] = ~lvl;
    endtask

    task automatic pass_pulse(int lane, logic lvl, int len, string tag);
        pulse(lane, lvl, len);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_bit({tag, " pulse passed"}, sync_clean[lane], lvl);
        idle(len + 6);
        check_bit({tag, " level restored"}, sync_clean[lane], ~lvl);
    endtask

    task automatic reject_pulse(int lane, logic lvl, int len, string tag);
        pulse(lane, lvl, len);
        for (int c = 0; c < len + 5; c++) begin
            @(negedge clk);
            check_bit({tag, " pulse suppressed"}, sync_clean[lane], ~lvl);
        end
    endtask

    task automatic latency(int n, string tag);
        sync_raw[0] = 1'b0;
        repeat (n + 1) @(posedge clk);
        @(negedge clk);
        check_bit({tag, " not yet"}, sync_clean[0], 1'b1);
        @(posedge clk);
        @(negedge clk);
        check_bit({tag, " on due edge"}, sync_clean[0], 1'b0);
        sync_raw[0] = 1'b1;
        idle(n + 6);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_bit("R1 in reset", sync_clean[0] & sync_clean[1] & sync_clean[2], 1'b1);
        rst = 1'b0;
        @(negedge clk);
        check_bit("R1 after release", sync_clean[0] & sync_clean[1] & sync_clean[2], 1'b1);
        idle(4);

        // R2: long window
        cur_req = "R2";
        reject_pulse(0, 1'b0, 4, "R2");
        pass_pulse(0, 1'b0, 5, "R2");
        pass_pulse(2, 1'b0, 8, "R2");

        // R6: latency for width 5
        cur_req = "R6";
        latency(5, "R6 width5");

        // R3: short window formats
        cur_req = "R3";
        for (int f = 1; f < 4; f++) begin
            fmt_class = 2'(f);
            idle(2);
            reject_pulse(1, 1'b0, 1, "R3");
            pass_pulse(1, 1'b0, 2, "R3");
        end
        latency(2, "R6 width2");

        // R5: lane resting low, high excursions
        cur_req = "R5";
        fmt_class = 2'd0;
        sync_raw[1] = 1'b0;
        idle(10);
        check_bit("R5 rests low", sync_clean[1], 1'b0);
        reject_pulse(1, 1'b1, 4, "R5");
        pass_pulse(1, 1'b1, 5, "R5");
        sync_raw[1] = 1'b1;
        idle(10);

        // R4: manual width
        cur_req = "R4";
        manual_en = 1'b1;
        manual_width = 4'd9;
        fmt_class = 2'd1;
        idle(2);
        reject_pulse(0, 1'b0, 8, "R4");
        pass_pulse(0, 1'b0, 9, "R4");
        manual_width = 4'd0;
        idle(2);
        pass_pulse(0, 1'b0, 1, "R4 zero");
        latency(1, "R6 width1");

        // R9: fixed variant ignores config (main width is 1 here)
        cur_req = "R9";
        pulse(2, 1'b0, 6);
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            check_bit("R9 fixed rejects 6", fix_clean[2], 1'b1);
        end
        pulse(2, 1'b0, 7);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_bit("R9 fixed passes 7", fix_clean[2], 1'b0);
        idle(14);

        // R7: config churn on stable lanes
        cur_req = "R7";
        for (int c = 0; c < 6; c++) begin
            manual_en = c[0];
            manual_width = 4'(c);
            fmt_class = 2'(c);
            idle(3);
            check_bit("R7 stable lane0", sync_clean[0], 1'b1);
            check_bit("R7 stable lane1", sync_clean[1], 1'b1);
        end
        manual_en = 1'b0;
        fmt_class = 2'd0;
        idle(1);
        reject_pulse(0, 1'b0, 2, "R7 new width");
        fmt_class = 2'd2;
        pass_pulse(0, 1'b0, 2, "R7 next transition");

        // R8: lane isolation
        cur_req = "R8";
        fmt_class = 2'd0;
        idle(2);
        sync_raw[0] = 1'b0;
        sync_raw[2] = 1'b0;
        repeat (3) @(negedge clk);
        sync_raw[2] = 1'b1;
        repeat (5) @(negedge clk);
        sync_raw[0] = 1'b1;
        check_bit("R8 lane0 low", sync_clean[0], 1'b0);
        check_bit("R8 lane1 untouched", sync_clean[1], 1'b1);
        check_bit("R8 lane2 suppressed", sync_clean[2], 1'b1);
        idle(12);

        // R10: mixed random traffic
        cur_req = "R10";
        for (int c = 0; c < 4000; c++) begin
            if (c % 150 == 0) begin
                manual_en = 1'($urandom_range(0, 1));
                manual_width = 4'($urandom_range(0, 12));
                fmt_class = 2'($urandom_range(0, 3));
            end
            for (int l = 0; l < LANES; l++)
                if ($urandom_range(0, 3) == 0) sync_raw[l] = ~sync_raw[l];
            @(negedge clk);
        end
        finish_run();
    end

endmodule